// File: doc/BRIEF.md
# ECC Error Status and Log Capture

This block sits beside a two-channel DRAM controller and records the ECC events that the controller's checker reports. In any cycle each channel may raise a correctable pulse, an uncorrectable pulse, or both. With the pulse come the column, row, bank, rank and syndrome of the failing access. A shared status word keeps one sticky flag for each class of error, and software clears a flag by writing 1 to it. Each channel also has a 64-bit log that keeps the details of one error. An uncorrectable error may replace a correctable entry that is already held. A correctable error can never displace anything that is held.

Software reaches the block through a plain register port with 32-bit words. The status word sits at word address 0. Each 64-bit log appears as a low word followed by a high word. A configuration input turns the block into a single-channel unit. In that mode the second channel's reports are ignored and its log reads as zero. An interrupt line is high whenever a status flag is set. Each channel also exports the global row index of its logged error.

Top module: `ecc_err_capture`

## Requirements
- R1: Out of reset, the status word and both logs read zero and `error_irq` is low.
- R2: Status bit 0 is set one cycle after a correctable pulse on any enabled channel, and status bit 1 one cycle after an uncorrectable pulse. Status bits 31:2 always read zero.
- R3: A register write to address 0 clears each status flag whose write-data bit is 1 and leaves the flags written with 0. If an error sets a flag in the same cycle as a clear of that flag, the flag stays 1.
- R4: An empty log (bits 1:0 = 00) that sees a correctable pulse captures the error. The layout is: column in 63:48, row in 47:32, bank in 31:29, rank in 28:27, syndrome in 23:16, bit 1 = uncorrectable, bit 0 = correctable. Bits 26:24 and 15:2 are zero.
- R5: A correctable pulse leaves the log unchanged while that log holds either status bit.
- R6: An uncorrectable pulse replaces a log that is empty or holds a correctable entry, and the log's bits 1:0 become 10. A log that already holds an uncorrectable entry keeps it.
- R7: When a channel raises both pulses in the same cycle, its log captures the error as uncorrectable.
- R8: A write of 1 to both status bits at once also clears bits 1:0 of every log, and keeps the other fields. A log event in the same cycle is still captured as if the log were empty.
- R9: While `single_chan` is 1, the pulses of channel 1 affect neither the status word nor its log, and channel 1's log reads zero.
- R10: Word address 1+2c reads bits 31:0 of channel c's log and address 2+2c reads bits 63:32. The other addresses read zero. Writes to any address other than 0 change nothing.
- R11: `error_irq` is 1 exactly when at least one status flag is set.
- R12: `row_idx` for channel c equals the logged rank plus 4·c (3 bits per channel, channel 0 in the low bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_chan | input | 1 | 1 disables channel 1 |
| ce_pulse | input | 2 | Correctable error pulse, bit c for channel c |
| ue_pulse | input | 2 | Uncorrectable error pulse, bit c for channel c |
| err_col | input | 32 | Column of the error, 16 bits per channel |
| err_row | input | 32 | Row of the error, 16 bits per channel |
| err_bank | input | 6 | Bank of the error, 3 bits per channel |
| err_rank | input | 4 | Rank of the error, 2 bits per channel |
| err_synd | input | 16 | Syndrome of the error, 8 bits per channel |
| reg_addr | input | 3 | Register word address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| error_irq | output | 1 | High while a status flag is set |
| row_idx | output | 6 | Global row index of each channel's logged error |

## Verification
The bench targets the collisions in this block. The first is a clear write landing in the same cycle as a new error. A design that let the clear win would lose the event, and a design that cleared logs on a partial clear would drop a held entry. Correctable pulses are sent into occupied logs, where a wrong design would overwrite the first error. Uncorrectable pulses are sent into correctable entries and into other uncorrectable entries; a design without the priority rule would keep stale details or overwrite the first fatal error. Single-channel mode and writes to the read-only log words are also exercised. A leaky design would show phantom channel 1 errors or corrupted logs.

// File: rtl/ecc_cap_pkg.sv
// Shared constants and log packing for the ECC error capture block.
// Assumes 4 ranks per channel and a 64-bit log read as two 32-bit words.
package ecc_cap_pkg;
    localparam int COL_W  = 16;
    localparam int ROW_W  = 16;
    localparam int BANK_W = 3;
    localparam int RANK_W = 2;
    localparam int SYND_W = 8;
    localparam int LOG_W  = 64;
    localparam int REG_W  = 32;
    localparam int RANKS_PER_CH = 1 << RANK_W;

    // Field positions inside a channel log
    localparam int COL_LSB  = 48;
    localparam int ROW_LSB  = 32;
    localparam int BANK_LSB = 29;
    localparam int RANK_LSB = 27;
    localparam int SYND_LSB = 16;
    localparam int UE_BIT   = 1;
    localparam int CE_BIT   = 0;

    typedef logic [LOG_W-1:0] log_word_t;

    // Build a log word from error fields and the two class bits
    function automatic log_word_t pack_log(
        input logic [COL_W-1:0]  col,
        input logic [ROW_W-1:0]  row,
        input logic [BANK_W-1:0] bank,
        input logic [RANK_W-1:0] rank,
        input logic [SYND_W-1:0] synd,
        input logic [1:0]        cls);
        log_word_t w;
        w = '0;
        w[COL_LSB  +: COL_W]  = col;
        w[ROW_LSB  +: ROW_W]  = row;
        w[BANK_LSB +: BANK_W] = bank;
        w[RANK_LSB +: RANK_W] = rank;
        w[SYND_LSB +: SYND_W] = synd;
        w[1:0]                = cls;
        return w;
    endfunction
endpackage

// File: rtl/ecc_cap_status.sv
// Sticky correctable/uncorrectable status flags with write-1-to-clear.
// Assumes set requests and clear masks arrive in the same cycle; set wins.
module ecc_cap_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_req,
    input  logic [1:0] clr_mask,
    output logic [1:0] flags
);
    // Update flags: clear by mask, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 2'b00;
        else        flags <= (flags & ~clr_mask) | set_req;
    end
endmodule

// File: rtl/ecc_cap_chan_log.sv
// One channel's 64-bit error log with uncorrectable-over-correctable priority.
// Assumes enable is static per test phase; a disabled channel holds zero.
module ecc_cap_chan_log
    import ecc_cap_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ce,
    input  logic              ue,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [BANK_W-1:0] bank,
    input  logic [RANK_W-1:0] rank,
    input  logic [SYND_W-1:0] synd,
    input  logic              clr_valid,
    output log_word_t         log_q,
    output logic [RIDX_W-1:0] row_idx
);
    logic [1:0] held;
    logic       take_ue;
    logic       take_ce;

    // Class bits as seen after a same-cycle clear
    always_comb begin
        held    = clr_valid ? 2'b00 : log_q[1:0];
        take_ue = ue && !held[UE_BIT];
        take_ce = ce && !ue && (held == 2'b00);
    end

    // Capture, hold or clear the log
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            log_q <= '0;
        end else if (take_ue) begin
            log_q <= pack_log(col, row, bank, rank, synd, 2'b10);
        end else if (take_ce) begin
            log_q <= pack_log(col, row, bank, rank, synd, 2'b01);
        end else if (clr_valid) begin
            log_q[1:0] <= 2'b00;
        end
    end

    // Global row index: logged rank offset by this channel's rank block
    always_comb begin
        row_idx = RIDX_W'(CH_IDX * RANKS_PER_CH) + RIDX_W'(log_q[RANK_LSB +: RANK_W]);
    end
endmodule

// File: rtl/ecc_cap_regport.sv
// Register port: status at word 0, log halves at 1+2c (low) and 2+2c (high).
// Assumes combinational reads; only word 0 is writable (write-1-to-clear).
module ecc_cap_regport
    import ecc_cap_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [1:0]           flags,
    input  logic [NCH*LOG_W-1:0] logs,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [1:0]           clr_mask,
    output logic                 clr_logs
);
    logic wdata_unused;
    assign wdata_unused = ^reg_wdata[REG_W-1:2];

    // Decode writes to the status word
    always_comb begin
        clr_mask = (reg_wr_en && reg_addr == '0) ? reg_wdata[1:0] : 2'b00;
        clr_logs = (clr_mask == 2'b11);
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata = {{(REG_W-2){1'b0}}, flags};
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == ADDR_W'(1 + 2*c))
                    reg_rdata = logs[c*LOG_W +: REG_W];
                if (reg_addr == ADDR_W'(2 + 2*c))
                    reg_rdata = logs[c*LOG_W + REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
// Top: ECC error status and per-channel log capture for a multi-channel DRAM
// controller. Assumes channel 0 is always enabled; single_chan disables the rest.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3,
    localparam int RIDX_W = $clog2(NCH * RANKS_PER_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    single_chan,
    input  logic [NCH-1:0]          ce_pulse,
    input  logic [NCH-1:0]          ue_pulse,
    input  logic [NCH*COL_W-1:0]    err_col,
    input  logic [NCH*ROW_W-1:0]    err_row,
    input  logic [NCH*BANK_W-1:0]   err_bank,
    input  logic [NCH*RANK_W-1:0]   err_rank,
    input  logic [NCH*SYND_W-1:0]   err_synd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr_en,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    error_irq,
    output logic [NCH*RIDX_W-1:0]   row_idx
);
    logic [NCH-1:0]       ch_en;
    logic [1:0]           st_flags;
    logic [1:0]           st_set;
    logic [1:0]           clr_mask;
    logic                 clr_logs;
    logic [NCH*LOG_W-1:0] log_flat;

    // Channel enables from the single-channel configuration
    always_comb begin
        for (int c = 0; c < NCH; c++) ch_en[c] = (c == 0) || !single_chan;
    end

    // Status set requests from enabled channels
    always_comb begin
        st_set[0] = |(ce_pulse & ch_en);
        st_set[1] = |(ue_pulse & ch_en);
    end

    ecc_cap_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (st_set),
        .clr_mask (clr_mask),
        .flags    (st_flags)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ecc_cap_chan_log #(.CH_IDX(c), .RIDX_W(RIDX_W)) u_log (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (ch_en[c]),
            .ce        (ce_pulse[c]),
            .ue        (ue_pulse[c]),
            .col       (err_col[c*COL_W +: COL_W]),
            .row       (err_row[c*ROW_W +: ROW_W]),
            .bank      (err_bank[c*BANK_W +: BANK_W]),
            .rank      (err_rank[c*RANK_W +: RANK_W]),
            .synd      (err_synd[c*SYND_W +: SYND_W]),
            .clr_valid (clr_logs),
            .log_q     (log_flat[c*LOG_W +: LOG_W]),
            .row_idx   (row_idx[c*RIDX_W +: RIDX_W])
        );
    end

    ecc_cap_regport #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .flags     (st_flags),
        .logs      (log_flat),
        .reg_rdata (reg_rdata),
        .clr_mask  (clr_mask),
        .clr_logs  (clr_logs)
    );

    // Interrupt while any flag is held
    assign error_irq = |st_flags;
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Property checker for ecc_err_capture, attached by bind.
// Assumes at least two channels for the single-channel property.
module ecc_err_capture_chk
    import ecc_cap_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 single_chan,
    input logic [NCH-1:0]       ce_pulse,
    input logic [NCH-1:0]       ue_pulse,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr_en,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic                 error_irq,
    input logic [1:0]           flags,
    input logic [NCH*LOG_W-1:0] logs
);
    logic [LOG_W-1:0] log0;
    logic             full_clr;
    assign log0     = logs[LOG_W-1:0];
    assign full_clr = reg_wr_en && reg_addr == '0 && reg_wdata[1:0] == 2'b11;

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0) |-> (error_irq == |reg_rdata[1:0]));

    // R2
    ue_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse[0] |=> flags[1]);

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse[0] && reg_wr_en && reg_addr == '0 && reg_wdata[0]) |=> flags[0]);

    // R5
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log0[1:0] != 2'b00 && ce_pulse[0] && !ue_pulse[0] && !full_clr) |=> $stable(log0));

    // R6
    ue_over_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_pulse[0] && log0[1:0] == 2'b01) |=> (log0[1:0] == 2'b10));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log0[26:24] == 3'b000) && (log0[15:2] == 14'h0));

    if (NCH > 1) begin : g_multi
        // R9
        single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            single_chan |=> (logs[2*LOG_W-1:LOG_W] == '0));
    end
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_chan (single_chan),
    .ce_pulse    (ce_pulse),
    .ue_pulse    (ue_pulse),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .error_irq   (error_irq),
    .flags       (st_flags),
    .logs        (log_flat)
);

// File: tb/ecc_err_capture_test.sv
// Self-checking bench: vector table walk, then directed corner cases.
module ecc_err_capture_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        single_chan = 0;
    logic [1:0]  ce_pulse = 0, ue_pulse = 0;
    logic [31:0] err_col = 0, err_row = 0;
    logic [5:0]  err_bank = 0;
    logic [3:0]  err_rank = 0;
    logic [15:0] err_synd = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr_en = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        error_irq;
    logic [5:0]  row_idx;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ecc_err_capture uut (.*);

    // {ce[1:0], ue[1:0], clr[1:0], status, log0 bits, log1 bits}
    localparam logic [11:0] VEC [0:12] = '{
        12'b01_00_00_01_01_00,
        12'b10_00_00_01_01_01,
        12'b01_00_00_01_01_01,
        12'b00_01_00_11_10_01,
        12'b00_01_00_11_10_01,
        12'b00_00_01_10_10_01,
        12'b10_00_00_11_10_01,
        12'b00_00_11_00_00_00,
        12'b01_00_01_01_01_00,
        12'b00_10_11_10_00_10,
        12'b10_10_00_11_00_10,
        12'b01_01_00_11_10_10,
        12'b00_00_11_00_00_00
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Drive one cycle of stimulus starting at a falling edge
    task automatic step(input logic [1:0] ce, input logic [1:0] ue,
                        input logic wr, input logic [2:0] a, input logic [31:0] wd);
        @(negedge clk);
        ce_pulse = ce; ue_pulse = ue;
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        ce_pulse = 0; ue_pulse = 0; reg_wr_en = 0; reg_wdata = 0;
    endtask

    task automatic set_fields(input int ch, input logic [15:0] col, input logic [15:0] row,
                              input logic [2:0] bank, input logic [1:0] rank, input logic [7:0] synd);
        err_col[ch*16 +: 16] = col;
        err_row[ch*16 +: 16] = row;
        err_bank[ch*3 +: 3]  = bank;
        err_rank[ch*2 +: 2]  = rank;
        err_synd[ch*8 +: 8]  = synd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, d); check("R1 status", d, 0);
        rd(1, d); check("R1 log0 lo", d, 0);
        rd(2, d); check("R1 log0 hi", d, 0);
        rd(3, d); check("R1 log1 lo", d, 0);
        check("R1 irq", {31'b0, error_irq}, 0);

        // Table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < 13; i++) begin
            logic [11:0] v;
            v = VEC[i];
            step(v[11:10], v[9:8], v[7:6] != 2'b00, 3'd0, {30'b0, v[7:6]});
            rd(0, d); check($sformatf("R2/R3 status vec %0d", i), d, {30'b0, v[5:4]});
            rd(1, d); check($sformatf("R6/R7/R8 log0 bits vec %0d", i), {30'b0, d[1:0]}, {30'b0, v[3:2]});
            rd(3, d); check($sformatf("R5/R8 log1 bits vec %0d", i), {30'b0, d[1:0]}, {30'b0, v[1:0]});
        end

        // R4 field layout, R12 row index, R11 irq
        set_fields(0, 16'hA5C3, 16'h1E2F, 3'b101, 2'b10, 8'h7B);
        step(2'b01, 2'b00, 0, 3'd0, 0);
        rd(1, d); check("R4 log0 lo", d, 32'hB07B0001);
        rd(2, d); check("R4 log0 hi", d, 32'hA5C31E2F);
        check("R12 row idx ch0", {29'b0, row_idx[2:0]}, 2);
        check("R11 irq set", {31'b0, error_irq}, 1);

        // R5 correctable into occupied log
        set_fields(0, 16'hFFFF, 16'hFFFF, 3'b111, 2'b11, 8'hFF);
        step(2'b01, 2'b00, 0, 3'd0, 0);
        rd(1, d); check("R5 log0 lo held", d, 32'hB07B0001);
        rd(2, d); check("R5 log0 hi held", d, 32'hA5C31E2F);

        // R6 uncorrectable replaces correctable
        set_fields(0, 16'h0F0F, 16'h3333, 3'b011, 2'b01, 8'hC4);
        step(2'b00, 2'b01, 0, 3'd0, 0);
        rd(1, d); check("R6 log0 lo", d, 32'h68C40002);
        rd(2, d); check("R6 log0 hi", d, 32'h0F0F3333);
        check("R12 row idx ch0 after ue", {29'b0, row_idx[2:0]}, 1);

        // R10 read-only logs and unmapped address; R2 upper status bits
        step(2'b00, 2'b00, 1, 3'd1, 32'hFFFFFFFF);
        rd(1, d); check("R10 log write ignored", d, 32'h68C40002);
        rd(5, d); check("R10 unmapped reads zero", d, 0);
        rd(0, d); check("R2 status upper zero", d, 32'h3);

        // R8 full clear keeps fields, R11 irq drops
        step(2'b00, 2'b00, 1, 3'd0, 32'h3);
        rd(0, d); check("R3 status cleared", d, 0);
        check("R11 irq clear", {31'b0, error_irq}, 0);
        rd(1, d); check("R8 log0 bits cleared", d, 32'h68C40000);

        // R9 single-channel mode
        single_chan = 1;
        set_fields(1, 16'h1234, 16'h5678, 3'b010, 2'b11, 8'h99);
        step(2'b10, 2'b10, 0, 3'd0, 0);
        rd(0, d); check("R9 status untouched", d, 0);
        rd(3, d); check("R9 log1 lo zero", d, 0);
        rd(4, d); check("R9 log1 hi zero", d, 0);

        // R12 channel 1 row index, R2 channel 1 sets status
        single_chan = 0;
        step(2'b10, 2'b00, 0, 3'd0, 0);
        check("R12 row idx ch1", {29'b0, row_idx[5:3]}, 7);
        rd(0, d); check("R2 ch1 correctable", d, 1);
        rd(4, d); check("R10 log1 hi", d, 32'h12345678);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule